// File: doc/BRIEF.md
# Motor-Driver Fault Supervisor

This block takes condition flags that an analog front end has already digitised and decides how the gate drivers of a three-phase bridge react. The flags are:

- logic-supply undervoltage
- regulator undervoltage
- one bootstrap undervoltage per phase
- temperature warning
- overtemperature
- short to ground, short to supply and shorted load

Every flag goes through a synchroniser. A per-diagnostic mask is then applied, and the flag is routed by fault class and by a stop-on-fault policy bit.

Three registered results come out:

- an active-low fault pin that follows conditions present now;
- a drive-disable output that forces all gate drives off so the motor coasts;
- a 16-bit sticky diagnostic word that keeps a history until software reads it.

Bootstrap shutdowns are latched. Short-fault shutdowns are also latched, but only under the stop-on-fault policy. These latches, and the sticky word, clear on an external active-low reset pin, on a read-complete strobe from the register interface, or on the synchronous power-on reset.

Top module: `mdrv_fault_supervisor`

## Requirements
- R1: While `rst` is high and after its release with no condition present, `fault_n` is 1, `drv_off` is 0 and `diag_word` is 0.
- R2: Logic-supply and regulator undervoltage set `diag_word` bit 0 and bit 1 respectively. They drive `fault_n` low and `drv_off` high for either `stop_on_fault` value, even when every mask bit is 1. They are not latched: `drv_off` returns to 0 once the condition clears.
- R3: Bootstrap undervoltage on phase p sets `diag_word` bit 4+p, drives `fault_n` low and forces `drv_off` high for either `stop_on_fault` value. The disable stays latched after the condition clears.
- R4: With `stop_on_fault` = 1, a short to ground (bit 7), short to supply (bit 8) or shorted load (bit 9) forces `drv_off` high. The disable stays latched after the condition clears.
- R5: With `stop_on_fault` = 0, a short fault sets its bit and pulls `fault_n` low while `drv_off` stays 0.
- R6: Overtemperature sets bit 10 and pulls `fault_n` low. It forces `drv_off` high only while `stop_on_fault` is 1, and that disable is not latched.
- R7: Temperature warning sets bit 11 and pulls `fault_n` low, and never raises `drv_off`. When the condition clears, `fault_n` returns high while bit 11 stays set.
- R8: Bit 15 of `diag_word` is set whenever any unmasked diagnostic sets its own bit.
- R9: A diagnostic whose `diag_mask` bit (same position as its status bit) is 1 affects neither `fault_n`, `drv_off` nor `diag_word`. Mask bits 0 and 1 have no effect. A mask change acts at the next clock edge.
- R10: A one-cycle `rd_done` pulse, or `ext_rst_n` low for a cycle, clears every sticky bit and every latched disable at that clock edge. A condition still present sets its bit again at the following edge.
- R11: Driving `stop_on_fault` to 0 does not release a disable already latched.
- R12: A condition input change reaches `fault_n` on the third rising clock edge after it is applied: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, sampled synchronously; clears latches and sticky word |
| rd_done | input | 1 | One-cycle strobe: a register read of the diagnostic word completed |
| stop_on_fault | input | 1 | Policy bit: 1 stops the drive on overtemperature and shorts |
| diag_mask | input | STAT_W | Per-diagnostic suppress bits, same positions as `diag_word` |
| vdd_uv | input | 1 | Logic-supply undervoltage flag (asynchronous) |
| vreg_uv | input | 1 | Regulator undervoltage flag (asynchronous) |
| boot_uv | input | NUM_PHASES | Bootstrap undervoltage flag per phase (asynchronous) |
| temp_warn | input | 1 | Temperature warning flag (asynchronous) |
| over_temp | input | 1 | Overtemperature flag (asynchronous) |
| short_gnd | input | 1 | Short-to-ground flag (asynchronous) |
| short_sup | input | 1 | Short-to-supply flag (asynchronous) |
| short_load | input | 1 | Shorted-load flag (asynchronous) |
| fault_n | output | 1 | Live fault pin, active low |
| drv_off | output | 1 | Gate-drive disable: 1 forces all gate drives low |
| diag_word | output | STAT_W | Sticky diagnostic status, bit 15 common flag |

## Verification
The bench builds the block with its defaults: three phases, a two-stage synchroniser and a 16-bit status word. With these values the bootstrap bits occupy positions 4 to 6 and the input-to-pin latency is exactly three edges, so R12 is checked cycle by cycle. Each fault class is driven under both policy settings and with masks applied. The latch tests remove the condition, drop the policy bit, and clear through both the read strobe and the reset pin. One test keeps a condition present across a read, which exposes the clear-then-reset ordering of the sticky bits.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  // Bit positions inside the diagnostic word; the register interface decodes these.
  localparam int DIAG_W    = 16;
  localparam int POS_VDD   = 0;
  localparam int POS_VREG  = 1;
  localparam int POS_BOOT  = 4;
  localparam int POS_SGND  = 7;
  localparam int POS_SSUP  = 8;
  localparam int POS_SLOAD = 9;
  localparam int POS_OT    = 10;
  localparam int POS_TW    = 11;
  localparam int POS_ANY   = 15;
endpackage

// File: rtl/mfs_sync.sv
module mfs_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mfs_response.sv
module mfs_response
  import mfs_pkg::*;
#(
  parameter int STAT_W     = DIAG_W,
  parameter int NUM_PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] eff,
  input  logic              esf,
  input  logic              clr,
  output logic              fault_n,
  output logic              drv_off
);
  logic uv_hit, boot_hit, short_hit, ot_hit, live_hit;
  logic set_latch, latch_q, latch_keep, disable_now;

  always_comb begin
    uv_hit    = eff[POS_VDD] | eff[POS_VREG];
    boot_hit  = |eff[POS_BOOT +: NUM_PHASES];
    short_hit = eff[POS_SGND] | eff[POS_SSUP] | eff[POS_SLOAD];
    ot_hit    = eff[POS_OT];
    live_hit  = |eff;
    // Shutdowns that must persist after the condition is gone.
    set_latch = boot_hit | (esf & short_hit);
    // A clear on this edge releases the stored shutdown at once.
    latch_keep  = latch_q & ~clr;
    disable_now = uv_hit | set_latch | (esf & ot_hit) | latch_keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      fault_n <= 1'b1;
      drv_off <= 1'b0;
    end else begin
      latch_q <= clr ? 1'b0 : (latch_q | set_latch);
      fault_n <= ~live_hit;
      drv_off <= disable_now;
    end
  end
endmodule

// File: rtl/mfs_sticky.sv
module mfs_sticky
  import mfs_pkg::*;
#(
  parameter int STAT_W = DIAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] eff,
  input  logic              clr,
  output logic [STAT_W-1:0] word
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == POS_ANY) begin : g_common
      always_ff @(posedge clk) begin
        if (rst || clr) word[i] <= 1'b0;
        else            word[i] <= word[i] | (|eff);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst || clr) word[i] <= 1'b0;
        else            word[i] <= word[i] | eff[i];
      end
    end
  end
endmodule

// File: rtl/mdrv_fault_supervisor.sv
module mdrv_fault_supervisor
  import mfs_pkg::*;
#(
  parameter int STAT_W      = DIAG_W,
  parameter int NUM_PHASES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_rst_n,
  input  logic                  rd_done,
  input  logic                  stop_on_fault,
  input  logic [STAT_W-1:0]     diag_mask,
  input  logic                  vdd_uv,
  input  logic                  vreg_uv,
  input  logic [NUM_PHASES-1:0] boot_uv,
  input  logic                  temp_warn,
  input  logic                  over_temp,
  input  logic                  short_gnd,
  input  logic                  short_sup,
  input  logic                  short_load,
  output logic                  fault_n,
  output logic                  drv_off,
  output logic [STAT_W-1:0]     diag_word
);
  // Supply faults and the common flag ignore the mask.
  localparam logic [STAT_W-1:0] LOCKED =
    STAT_W'((1 << POS_VDD) | (1 << POS_VREG) | (1 << POS_ANY));

  logic [STAT_W-1:0] cond_vec, sync_vec, eff_vec;
  logic              clr;

  always_comb begin
    cond_vec                           = '0;
    cond_vec[POS_VDD]                  = vdd_uv;
    cond_vec[POS_VREG]                 = vreg_uv;
    cond_vec[POS_BOOT +: NUM_PHASES]   = boot_uv;
    cond_vec[POS_SGND]                 = short_gnd;
    cond_vec[POS_SSUP]                 = short_sup;
    cond_vec[POS_SLOAD]                = short_load;
    cond_vec[POS_OT]                   = over_temp;
    cond_vec[POS_TW]                   = temp_warn;
  end

  mfs_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cond_vec),
    .q   (sync_vec)
  );

  assign eff_vec = sync_vec & ~(diag_mask & ~LOCKED);
  assign clr     = rd_done | ~ext_rst_n;

  mfs_response #(.STAT_W(STAT_W), .NUM_PHASES(NUM_PHASES)) u_resp (
    .clk     (clk),
    .rst     (rst),
    .eff     (eff_vec),
    .esf     (stop_on_fault),
    .clr     (clr),
    .fault_n (fault_n),
    .drv_off (drv_off)
  );

  mfs_sticky #(.STAT_W(STAT_W)) u_sticky (
    .clk  (clk),
    .rst  (rst),
    .eff  (eff_vec),
    .clr  (clr),
    .word (diag_word)
  );
endmodule

// File: rtl/mdrv_fault_supervisor_chk.sv
module mdrv_fault_supervisor_chk
  import mfs_pkg::*;
#(
  parameter int STAT_W = DIAG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_rst_n,
  input logic              rd_done,
  input logic [STAT_W-1:0] diag_mask,
  input logic              fault_n,
  input logic              drv_off,
  input logic [STAT_W-1:0] diag_word
);
  logic prev_rst = 1'b0;
  logic unused_mask;
  assign unused_mask = &{1'b0, diag_mask[POS_VREG:POS_VDD], diag_mask[POS_ANY]};

  always @(posedge clk) prev_rst <= rst;

  // R1
  always @(negedge clk) begin
    if (prev_rst) begin
      reset_state_chk: assert (fault_n && !drv_off && diag_word == '0);
    end
  end

  // R8
  common_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (diag_word[POS_ANY-1:0] != '0) |-> diag_word[POS_ANY]);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> (diag_word == '0));

  // R10
  ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n |=> (diag_word == '0));

  // R2
  disable_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_off) |-> !fault_n);

  for (genvar b = POS_VREG + 1; b < POS_ANY; b++) begin : g_mask
    // R9
    mask_suppress_chk: assert property (@(posedge clk) disable iff (rst)
      (diag_word[b] && !$past(diag_word[b])) |-> !$past(diag_mask[b]));
  end
endmodule

bind mdrv_fault_supervisor mdrv_fault_supervisor_chk #(.STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ext_rst_n (ext_rst_n),
  .rd_done   (rd_done),
  .diag_mask (diag_mask),
  .fault_n   (fault_n),
  .drv_off   (drv_off),
  .diag_word (diag_word)
);

// File: tb/mdrv_fault_supervisor_test.sv
`timescale 1ns/1ps
module mdrv_fault_supervisor_test;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_rst_n = 1'b1;
  logic          rd_done = 1'b0;
  logic          stop_on_fault = 1'b0;
  logic [15:0]   diag_mask = '0;
  logic          vdd_uv = 1'b0, vreg_uv = 1'b0;
  logic [NP-1:0] boot_uv = '0;
  logic          temp_warn = 1'b0, over_temp = 1'b0;
  logic          short_gnd = 1'b0, short_sup = 1'b0, short_load = 1'b0;
  logic          fault_n, drv_off;
  logic [15:0]   diag_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdrv_fault_supervisor uut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .rd_done(rd_done),
    .stop_on_fault(stop_on_fault), .diag_mask(diag_mask),
    .vdd_uv(vdd_uv), .vreg_uv(vreg_uv), .boot_uv(boot_uv),
    .temp_warn(temp_warn), .over_temp(over_temp),
    .short_gnd(short_gnd), .short_sup(short_sup), .short_load(short_load),
    .fault_n(fault_n), .drv_off(drv_off), .diag_word(diag_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic outs(input string req, input logic fn, input logic dof, input logic [15:0] dw);
    check({req, " fault_n"}, {15'd0, fault_n}, {15'd0, fn});
    check({req, " drv_off"}, {15'd0, drv_off}, {15'd0, dof});
    check({req, " diag_word"}, diag_word, dw);
  endtask

  task automatic pulse_read();
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk) ext_rst_n = 1'b0;
    @(negedge clk) ext_rst_n = 1'b1;
  endtask

  task automatic clean();
    vdd_uv = 0; vreg_uv = 0; boot_uv = '0; temp_warn = 0; over_temp = 0;
    short_gnd = 0; short_sup = 0; short_load = 0;
    stop_on_fault = 0; diag_mask = '0;
    settle();
    pulse_ext();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    outs("R1 in reset", 1'b1, 1'b0, 16'h0000);
    rst = 1'b0;
    settle();
    outs("R1 after reset", 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_warn_latency();
    @(negedge clk) temp_warn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 pin still high after two edges", {15'd0, fault_n}, 16'd1);
    @(negedge clk);
    check("R12 pin low on third edge", {15'd0, fault_n}, 16'd0);
    settle();
    outs("R7 warning present", 1'b0, 1'b0, 16'h8800);
    temp_warn = 1'b0;
    settle();
    outs("R7 warning released, bit sticky", 1'b1, 1'b0, 16'h8800);
    pulse_read();
    check("R10 read clears word", diag_word, 16'h0000);
    clean();
  endtask

  task automatic t_supply();
    diag_mask = 16'hFFFF;
    vdd_uv = 1'b1;
    settle();
    outs("R2 vdd uv esf0 masked", 1'b0, 1'b1, 16'h8001);
    vdd_uv = 1'b0;
    settle();
    outs("R2 vdd uv not latched", 1'b1, 1'b0, 16'h8001);
    clean();
    diag_mask = 16'hFFFF;
    stop_on_fault = 1'b1;
    vreg_uv = 1'b1;
    settle();
    outs("R2 vreg uv esf1 masked", 1'b0, 1'b1, 16'h8002);
    vreg_uv = 1'b0;
    settle();
    check("R2 vreg uv not latched", {15'd0, drv_off}, 16'd0);
    clean();
  endtask

  task automatic t_boot();
    boot_uv = 3'b010;
    settle();
    outs("R3 boot uv phase1 esf0", 1'b0, 1'b1, 16'h8020);
    boot_uv = '0;
    settle();
    outs("R3 boot disable latched", 1'b1, 1'b1, 16'h8020);
    pulse_read();
    outs("R10 read releases boot latch", 1'b1, 1'b0, 16'h0000);
    clean();
  endtask

  task automatic t_short_stop();
    stop_on_fault = 1'b1;
    short_gnd = 1'b1;
    settle();
    outs("R4 short gnd esf1", 1'b0, 1'b1, 16'h8080);
    short_gnd = 1'b0;
    settle();
    check("R4 short disable latched", {15'd0, drv_off}, 16'd1);
    stop_on_fault = 1'b0;
    settle();
    check("R11 esf drop keeps latch", {15'd0, drv_off}, 16'd1);
    pulse_ext();
    check("R10 ext reset releases latch", {15'd0, drv_off}, 16'd0);
    stop_on_fault = 1'b1;
    short_sup = 1'b1;
    settle();
    outs("R4 short sup esf1", 1'b0, 1'b1, 16'h8100);
    pulse_read();
    outs("R10 read with fault present", 1'b0, 1'b1, 16'h0000);
    @(negedge clk);
    check("R10 bit set again next cycle", diag_word, 16'h8100);
    clean();
  endtask

  task automatic t_short_run();
    short_load = 1'b1;
    settle();
    outs("R5 shorted load esf0", 1'b0, 1'b0, 16'h8200);
    short_load = 1'b0;
    settle();
    outs("R5 shorted load cleared", 1'b1, 1'b0, 16'h8200);
    clean();
  endtask

  task automatic t_overtemp();
    stop_on_fault = 1'b1;
    over_temp = 1'b1;
    settle();
    outs("R6 overtemp esf1", 1'b0, 1'b1, 16'h8400);
    over_temp = 1'b0;
    settle();
    check("R6 overtemp not latched", {15'd0, drv_off}, 16'd0);
    clean();
    over_temp = 1'b1;
    settle();
    outs("R6 overtemp esf0", 1'b0, 1'b0, 16'h8400);
    clean();
  endtask

  task automatic t_mask();
    stop_on_fault = 1'b1;
    diag_mask = 16'h0900;
    short_sup = 1'b1;
    temp_warn = 1'b1;
    settle();
    outs("R9 masked short and warning", 1'b1, 1'b0, 16'h0000);
    diag_mask = 16'h0800;
    @(negedge clk);
    outs("R9 unmask acts next edge", 1'b0, 1'b1, 16'h8100);
    clean();
  endtask

  initial begin
    t_reset();
    t_warn_latency();
    t_supply();
    t_boot();
    t_short_stop();
    t_short_run();
    t_overtemp();
    t_mask();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule